// File: doc/BRIEF.md
# Line-Scan Camera Output Simulator

This block stands in for a four-channel line-scan camera so that a frame grabber can be brought up and tested without a sensor. It runs from one master clock. It produces a pixel strobe at half the master rate, and on that strobe it steps through a repeating line. Each line has three parts, in this order: 3072 active pixels that carry a grey-level ramp, then 1024 pixels forced to zero, then a short blanking gap whose length is programmable.

A blanking flag is high only during the gap, so the line-valid sense is active low. A one-pixel trigger pulse marks the last gap pixel, which means it ends on the same edge where the blanking flag falls. All four 8-bit channels share these controls. Each channel adds its own fixed offset to a common free-running ramp, so the channels can be told apart.

All outputs are single-ended and synchronous to the master clock. They change only on the master edge that follows a cycle in which the pixel strobe is high. A grabber model therefore samples them in the strobe-high cycles.

Top module: `linescan_pattern_src`

## Requirements
- R1: While `rst` is high, and on the first master cycle after a reset edge, `pix_stb`, `trig` and `line_valid_n` are 0. Channel n of `pix_data` shows 64·n, which is ramp value 0 plus the channel offset.
- R2: After reset, `pix_stb` alternates on every master clock and starts at 0. The outputs hold their value through any cycle in which `pix_stb` is 0. The line position and the ramp advance only on the master edge that ends a cycle with `pix_stb` high.
- R3: Pixels 0 to 3071 of a line form the active region. In this region `line_valid_n` is 0 and channel n (bits [8n+7:8n] of `pix_data`) equals (ramp + 64·n) mod 256.
- R4: The ramp starts at 0 after reset, advances by 1 on every pixel of every region, and wraps from 255 to 0. It keeps counting through the zero region and the gap, so pixel 0 of the second line after reset shows ramp value 4100 mod 256 = 4 when the gap is 4.
- R5: Pixels 3072 to 4095 form the zero region. In this region `line_valid_n` is 0 and every channel is 0.
- R6: Pixels 4096 onward form the gap, which lasts G pixels. In the gap `line_valid_n` is 1 and every channel is 0. With `gap_len` = 4 the line period is 4100 pixels.
- R7: `trig` is 1 only during the last gap pixel, for exactly one pixel period. On the next pixel `trig` and `line_valid_n` are both 0.
- R8: The gap length G is taken from `gap_len` only while `rst` is high and on the edge that starts a new line. A change to `gap_len` during a line takes effect on the following line.
- R9: A sampled `gap_len` of 0 gives a gap of one pixel, so the line period is 4097.
- R10: Asserting `rst` in the middle of a line restarts the line at active pixel 0 with the ramp at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| gap_len | input | GAP_W (8) | Requested blanking gap length in pixels, sampled at line start |
| pix_stb | output | 1 | Pixel strobe, high every second master cycle |
| line_valid_n | output | 1 | High only during the blanking gap (active-low line valid) |
| trig | output | 1 | One-pixel pulse on the last gap pixel |
| pix_data | output | NUM_CH·PIX_W (32) | Channel n occupies bits [8n+7:8n] |

## Verification
The bench targets the region boundaries at pixels 3071/3072, 4095/4096 and the last gap pixel. An off-by-one in the position decode there would leak ramp data into the zero region or stretch the gap by one pixel. It measures whole line periods and gap lengths while `gap_len` changes in the middle of a line and is set to 0. A design that samples the gap length continuously would shorten or lengthen the line in progress, and one that passes 0 through unchanged would produce a line with no trigger at all. It also checks that the ramp value carries over from one line to the next, and that a reset in the middle of a line brings back the reset pattern at pixel 0.

// File: rtl/lsc_pkg.sv
package lsc_pkg;

    // Region of the line the current pixel belongs to
    typedef enum logic [1:0] {
        SEG_ACTIVE = 2'd0,
        SEG_ZERO   = 2'd1,
        SEG_GAP    = 2'd2
    } seg_e;

    // Control outputs shared by all channels
    typedef struct packed {
        logic blank;   // high during the gap (active-low line valid)
        logic pulse;   // one-pixel trigger
    } ctrl_t;

    // Map the position summary onto the control outputs
    function automatic ctrl_t decode_ctrl(input seg_e seg, input logic line_end);
        ctrl_t c;
        c.blank = (seg == SEG_GAP);
        c.pulse = (seg == SEG_GAP) && line_end;
        return c;
    endfunction

endpackage

// File: rtl/lsc_pix_divider.sv
// Divide-by-2 enable: high on every second master cycle.
module lsc_pix_divider (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    always_ff @(posedge clk) begin
        if (rst) tick <= 1'b0;
        else     tick <= ~tick;
    end
endmodule

// File: rtl/lsc_line_timer.sv
// Pixel position within the line and the gap length latched at line start.
module lsc_line_timer
    import lsc_pkg::*;
#(
    parameter int ACT_PIX  = 3072,
    parameter int ZERO_PIX = 1024,
    parameter int GAP_W    = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic [GAP_W-1:0] gap_len,
    output seg_e             seg,
    output logic             line_end
);
    localparam int BASE     = ACT_PIX + ZERO_PIX;
    localparam int LINE_MAX = BASE + (1 << GAP_W) - 1;
    localparam int POS_W    = $clog2(LINE_MAX + 1);

    logic [POS_W-1:0] pos;
    logic [GAP_W-1:0] gap_cur;
    logic [GAP_W-1:0] gap_next;
    logic [POS_W-1:0] end_pos;

    // A zero request is widened to one pixel so every line has a trigger
    assign gap_next = (gap_len == '0) ? GAP_W'(1) : gap_len;
    assign end_pos  = POS_W'(BASE) + POS_W'(gap_cur) - POS_W'(1);
    assign line_end = (pos == end_pos);

    always_ff @(posedge clk) begin
        if (rst) begin
            pos     <= '0;
            gap_cur <= gap_next;
        end else if (tick) begin
            if (line_end) begin
                pos     <= '0;
                gap_cur <= gap_next;
            end else begin
                pos <= pos + POS_W'(1);
            end
        end
    end

    always_comb begin
        if (pos < POS_W'(ACT_PIX))   seg = SEG_ACTIVE;
        else if (pos < POS_W'(BASE)) seg = SEG_ZERO;
        else                         seg = SEG_GAP;
    end
endmodule

// File: rtl/lsc_ramp_gen.sv
// Free-running grey ramp with a fixed offset per channel.
module lsc_ramp_gen
    import lsc_pkg::*;
#(
    parameter int NUM_CH  = 4,
    parameter int PIX_W   = 8,
    parameter int CH_STEP = 64
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    tick,
    input  seg_e                    seg,
    output logic [NUM_CH*PIX_W-1:0] data
);
    logic [PIX_W-1:0] ramp;

    always_ff @(posedge clk) begin
        if (rst)       ramp <= '0;
        else if (tick) ramp <= ramp + PIX_W'(1);
    end

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        assign data[ch*PIX_W +: PIX_W] =
            (seg == SEG_ACTIVE) ? ramp + PIX_W'(CH_STEP * ch) : '0;
    end
endmodule

// File: rtl/linescan_pattern_src.sv
module linescan_pattern_src
    import lsc_pkg::*;
#(
    parameter int NUM_CH   = 4,
    parameter int PIX_W    = 8,
    parameter int CH_STEP  = 64,
    parameter int ACT_PIX  = 3072,
    parameter int ZERO_PIX = 1024,
    parameter int GAP_W    = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [GAP_W-1:0]        gap_len,
    output logic                    pix_stb,
    output logic                    line_valid_n,
    output logic                    trig,
    output logic [NUM_CH*PIX_W-1:0] pix_data
);
    logic  tick;
    logic  line_end;
    seg_e  seg;
    ctrl_t ctrl;

    lsc_pix_divider u_div (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    lsc_line_timer #(
        .ACT_PIX  (ACT_PIX),
        .ZERO_PIX (ZERO_PIX),
        .GAP_W    (GAP_W)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .gap_len  (gap_len),
        .seg      (seg),
        .line_end (line_end)
    );

    lsc_ramp_gen #(
        .NUM_CH  (NUM_CH),
        .PIX_W   (PIX_W),
        .CH_STEP (CH_STEP)
    ) u_ramp (
        .clk  (clk),
        .rst  (rst),
        .tick (tick),
        .seg  (seg),
        .data (pix_data)
    );

    assign ctrl         = decode_ctrl(seg, line_end);
    assign pix_stb      = tick;
    assign line_valid_n = ctrl.blank;
    assign trig         = ctrl.pulse;
endmodule

// File: rtl/lsc_checker.sv
module lsc_checker #(
    parameter int NUM_CH = 4,
    parameter int PIX_W  = 8
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    pix_stb,
    input logic                    line_valid_n,
    input logic                    trig,
    input logic [NUM_CH*PIX_W-1:0] pix_data
);
    // R1: controls come out of reset low
    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (!pix_stb && !trig && !line_valid_n));

    // R2: strobe alternates once running
    assert_stb_toggle_R2: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) |-> (pix_stb != $past(pix_stb)));

    // R2: outputs hold across a strobe-low cycle
    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !pix_stb |=> ($stable(line_valid_n) && $stable(trig) && $stable(pix_data)));

    // R5: the gap is always entered from a zero pixel
    assert_zero_before_gap_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(line_valid_n) |-> ($past(pix_data) == '0));

    // R6: no data during the gap
    assert_gap_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        line_valid_n |-> (pix_data == '0));

    // R7: trigger lies inside the gap
    assert_trig_in_gap_R7: assert property (@(posedge clk) disable iff (rst)
        trig |-> line_valid_n);

    // R7: trigger lasts one pixel and ends with the gap
    assert_trig_single_R7: assert property (@(posedge clk) disable iff (rst)
        (trig && pix_stb) |=> (!trig && !line_valid_n));
endmodule

bind linescan_pattern_src lsc_checker #(
    .NUM_CH (NUM_CH),
    .PIX_W  (PIX_W)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .pix_stb      (pix_stb),
    .line_valid_n (line_valid_n),
    .trig         (trig),
    .pix_data     (pix_data)
);

// File: tb/sim_linescan_pattern_src.sv
`timescale 1ns/1ps
module sim_linescan_pattern_src;
    localparam int NCH  = 4;
    localparam int PW   = 8;
    localparam int ACT  = 3072;
    localparam int ZER  = 1024;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [7:0] gap_len = 8'd4;
    logic pix_stb, line_valid_n, trig;
    logic [NCH*PW-1:0] pix_data;

    always #5 clk = ~clk;

    linescan_pattern_src u0 (
        .clk          (clk),
        .rst          (rst),
        .gap_len      (gap_len),
        .pix_stb      (pix_stb),
        .line_valid_n (line_valid_n),
        .trig         (trig),
        .pix_data     (pix_data)
    );

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // Behavioural reference: pixel index, ramp, latched gap
    int m_pix = 0, m_ramp = 0, m_gap = 4;
    bit m_stb = 0, m_valid = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_stb = 0; m_pix = 0; m_ramp = 0;
            m_gap = (gap_len == 0) ? 1 : int'(gap_len);
        end else begin
            if (m_stb) begin
                m_ramp = (m_ramp + 1) % 256;
                if (m_pix == ACT + ZER + m_gap - 1) begin
                    m_pix = 0;
                    m_gap = (gap_len == 0) ? 1 : int'(gap_len);
                end else m_pix++;
            end
            m_stb = !m_stb;
        end
        m_valid = 1;
    end

    function automatic logic [NCH*PW-1:0] exp_data(input int pix, input int ramp);
        logic [NCH*PW-1:0] d = '0;
        if (pix < ACT)
            for (int n = 0; n < NCH; n++) d[n*PW +: PW] = PW'((ramp + 64*n) % 256);
        return d;
    endfunction

    // Monitor: per-clock comparison and line measurements
    int pcnt = 0, gcnt = 0, trig_n = 0;
    int per_q[$];
    int gap_q[$];
    bit chk_line1 = 0;
    int prev_ch0 = -1;

    always @(negedge clk) begin
        if (m_valid && !done) begin
            string rt;
            logic [NCH*PW-1:0] ed;
            ed = exp_data(m_pix, m_ramp);
            rt = rst ? "R1/R10" : (m_pix < ACT) ? "R3" : (m_pix < ACT + ZER) ? "R5" : "R6";
            chk(pix_stb == m_stb, "R2 strobe", pix_stb, m_stb);
            chk(pix_data == ed, {rt, " data"}, pix_data, ed);
            chk(line_valid_n == (m_pix >= ACT + ZER), {rt, " line_valid_n"},
                line_valid_n, (m_pix >= ACT + ZER));
            chk(trig == (m_pix == ACT + ZER + m_gap - 1), "R7 trig", trig,
                (m_pix == ACT + ZER + m_gap - 1));
        end
        if (rst) begin
            pcnt = 0; gcnt = 0; prev_ch0 = -1;
        end else if (!done) begin
            if (chk_line1) begin
                chk(pix_data[7:0] == 8'd4, "R4 ramp carried into line 1", pix_data[7:0], 4);
                chk_line1 = 0;
            end
            if (pix_stb) begin
                if (m_pix < ACT) begin
                    if (prev_ch0 >= 0 && m_pix > 0)
                        chk(int'(pix_data[7:0]) == (prev_ch0 + 1) % 256, "R4 ramp step",
                            pix_data[7:0], (prev_ch0 + 1) % 256);
                    prev_ch0 = int'(pix_data[7:0]);
                end
                pcnt++;
                if (line_valid_n) gcnt++;
                if (trig) begin
                    per_q.push_back(pcnt);
                    gap_q.push_back(gcnt);
                    pcnt = 0; gcnt = 0;
                    trig_n++;
                    if (trig_n == 1) chk_line1 = 1;
                end
            end
        end
    end

    // Watchdog
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1;
            fails++; total++;
            $display("FAIL watchdog actual=%0d expected<=150000", cyc);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(pix_stb == 0 && trig == 0 && line_valid_n == 0, "R1 controls in reset",
            {pix_stb, trig, line_valid_n}, 0);
        chk(pix_data == 32'hC0804000, "R1 data in reset", pix_data, 32'hC0804000);
        rst = 0;
        wait (trig_n == 1);
        @(negedge clk) gap_len = 8'd7;      // R8: mid-line change, applies to line 2
        wait (trig_n == 2);
        @(negedge clk) gap_len = 8'd0;      // R9: zero becomes one
        wait (trig_n == 4);
        gap_len = 8'd4;
        repeat (600) @(negedge clk);
        rst = 1;                              // R10: reset mid-line
        repeat (2) @(negedge clk);
        chk(line_valid_n == 0 && trig == 0 && pix_stb == 0, "R10 controls after reset",
            {pix_stb, trig, line_valid_n}, 0);
        chk(pix_data == 32'hC0804000, "R10 data restart", pix_data, 32'hC0804000);
        rst = 0;
        repeat (60) @(negedge clk);
        done = 1;
        chk(per_q.size() >= 4, "R6 lines observed", per_q.size(), 4);
        if (per_q.size() >= 4) begin
            chk(per_q[0] == 4100, "R6 period gap 4", per_q[0], 4100);
            chk(per_q[1] == 4100, "R8 period unchanged mid-line", per_q[1], 4100);
            chk(per_q[2] == 4103, "R8 period new gap", per_q[2], 4103);
            chk(per_q[3] == 4097, "R9 period zero gap", per_q[3], 4097);
            chk(gap_q[0] == 4, "R6 gap length", gap_q[0], 4);
            chk(gap_q[1] == 4, "R8 gap kept", gap_q[1], 4);
            chk(gap_q[2] == 7, "R8 gap applied", gap_q[2], 7);
            chk(gap_q[3] == 1, "R9 gap one", gap_q[3], 1);
        end
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule